// File: doc/BRIEF.md
# Dual-Width Instruction Prefetch Queue

This block sits between instruction memory and the decoder of a core that runs either a 32-bit or a 16-bit instruction set. It holds two queued fetch slots. On every step it hands the oldest slot to the decoder, moves the younger slot forward, and reads a new word at the program counter into the young slot. The fetch width and the program counter increment follow a mode input.

A redirect (a branch, or a change of instruction set) is requested by raising the flush input together with a step and supplying the new target address. Both slots are then marked empty, the fetch made in that step is thrown away, and the program counter takes the target instead of advancing. The decoder sees no valid instruction on the next two steps. The instruction at the target comes out on the third step. Each issued instruction comes with a trace address that points back at the instruction itself.

Top module: `dual_width_prefetch`

## Requirements
- R1: After synchronous reset both slots are empty, `issue_valid_o` is 0 and `pc_o` equals the parameter `RESET_PC` (default 0). From reset, the first valid issue appears on the third step and carries the word read at `RESET_PC`.
- R2: The read request is combinational and reflects the current state: `mem_addr_o` equals `pc_o`, and `mem_half_o` equals `half_mode_i` (1 means a 16-bit fetch). `mem_rdata_i` is taken in the same cycle.
- R3: On a step without flush, the clock edge registers the old slot 0 as the issued instruction. Slot 1 moves into slot 0, and the word at `pc_o` fills slot 1 as valid. A word fetched on step k is therefore issued on step k+2.
- R4: On a step without flush, `pc_o` advances by 4 when `half_mode_i` is 0 and by 2 when it is 1.
- R5: On a step with `flush_i`=1, both slots become empty and the fetch of that step is discarded. `pc_o` then takes `flush_pc_i` and is not advanced.
- R6: A step with flush still issues what slot 0 held before the edge, if that slot was valid.
- R7: After a flush step, the next two steps issue nothing. The third step issues the word read at the flush target.
- R8: When `half_mode_i` is 1 during the issuing step, `issue_instr_o` holds the low 16 bits of the slot, and bits 31:16 are zero. In 32-bit mode all 32 bits are issued.
- R9: `trace_pc_o` is `pc_o` at the issuing step minus 8 in 32-bit mode or minus 4 in 16-bit mode. If `pc_o` is smaller than that offset, `trace_pc_o` is 0.
- R10: A cycle with `step_i`=0 leaves the slots and `pc_o` unchanged and issues nothing, whatever `flush_i`, `flush_pc_i` and `half_mode_i` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance the queue this cycle |
| flush_i | input | 1 | Redirect: empty the slots and load the target (only with step_i) |
| flush_pc_i | input | PC_W | Redirect target address |
| half_mode_i | input | 1 | 1 selects the 16-bit instruction set, 0 the 32-bit set |
| mem_addr_o | output | PC_W | Fetch address |
| mem_half_o | output | 1 | Fetch size: 1 = 16-bit, 0 = 32-bit |
| mem_rdata_i | input | 32 | Fetched data, returned in the same cycle |
| issue_valid_o | output | 1 | Registered: an instruction was issued on the last step |
| issue_instr_o | output | 32 | Registered issued instruction |
| trace_pc_o | output | PC_W | Registered address of the issued instruction |
| pc_o | output | PC_W | Current program counter |

## Verification
The issue outputs, `trace_pc_o` and `pc_o` are all registered. Each one therefore shows the effect of a step one clock edge after the step is driven. A word fetched on a step reaches `issue_instr_o` two steps later. The fetch request itself is combinational and is checked in the same cycle, before the edge. The bench drives each step on the falling edge and checks the fetch request right away. It then waits through one rising edge and compares the registered results at the next falling edge against a step model. Idle cycles sit between steps, so the two-step refill delay is counted in steps and not in clock cycles.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int INSTR_W   = 32;
  localparam int HALF_W    = 16;
  localparam int NUM_SLOTS = 2;

  typedef struct packed {
    logic               vld;
    logic [INSTR_W-1:0] word;
  } slot_t;
endpackage

// File: rtl/pfq_pc_reg.sv
module pfq_pc_reg #(
  parameter int          PC_W     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_i,
  input  logic            flush_i,
  input  logic [PC_W-1:0] flush_pc_i,
  input  logic            half_i,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] INC_WORD = PC_W'(4);
  localparam logic [PC_W-1:0] INC_HALF = PC_W'(2);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= RESET_PC[PC_W-1:0];
    else if (step_i && flush_i)
      pc_q <= flush_pc_i;
    else if (step_i)
      pc_q <= pc_q + (half_i ? INC_HALF : INC_WORD);
  end

  assign pc_o = pc_q;

  assert_flush_loads_target_R5: assert property (@(posedge clk) disable iff (rst)
    (step_i && flush_i) |=> (pc_q == $past(flush_pc_i)));

  assert_word_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (step_i && !flush_i && !half_i) |=> (pc_q == $past(pc_q) + INC_WORD));

  assert_half_advance_R4: assert property (@(posedge clk) disable iff (rst)
    (step_i && !flush_i && half_i) |=> (pc_q == $past(pc_q) + INC_HALF));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(pc_q));
endmodule

// File: rtl/pfq_slot_queue.sv
module pfq_slot_queue
  import pfq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               step_i,
  input  logic               flush_i,
  input  logic [INSTR_W-1:0] fetch_word_i,
  output slot_t              head_o
);
  slot_t slot_q [NUM_SLOTS];
  slot_t fill;

  always_comb begin
    fill.vld  = 1'b1;
    fill.word = fetch_word_i;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    slot_t nxt;
    if (i == NUM_SLOTS - 1) begin : g_tail
      assign nxt = fill;
    end else begin : g_mid
      assign nxt = slot_q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[i].vld  <= 1'b0;
        slot_q[i].word <= '0;
      end else if (step_i && flush_i) begin
        slot_q[i].vld  <= 1'b0;
      end else if (step_i) begin
        slot_q[i] <= nxt;
      end
    end
  end

  assign head_o = slot_q[0];

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (rst)
    (step_i && flush_i) |=> (!slot_q[0].vld && !slot_q[NUM_SLOTS-1].vld));

  assert_plain_step_fills_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !flush_i) |=> (slot_q[NUM_SLOTS-1].vld &&
                              slot_q[NUM_SLOTS-1].word == $past(fetch_word_i)));
endmodule

// File: rtl/pfq_issue.sv
module pfq_issue
  import pfq_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_i,
  input  logic               half_i,
  input  slot_t              head_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic               issue_valid_o,
  output logic [INSTR_W-1:0] issue_instr_o,
  output logic [PC_W-1:0]    trace_pc_o
);
  localparam logic [PC_W-1:0] LAG_WORD = PC_W'(8);
  localparam logic [PC_W-1:0] LAG_HALF = PC_W'(4);

  logic [PC_W-1:0]    lag;
  logic [PC_W-1:0]    trace_d;
  logic [INSTR_W-1:0] instr_d;

  always_comb begin
    lag     = half_i ? LAG_HALF : LAG_WORD;
    trace_d = (pc_i < lag) ? '0 : pc_i - lag;
    instr_d = half_i ? {{(INSTR_W-HALF_W){1'b0}}, head_i.word[HALF_W-1:0]}
                     : head_i.word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid_o <= 1'b0;
      issue_instr_o <= '0;
      trace_pc_o    <= '0;
    end else begin
      issue_valid_o <= step_i && head_i.vld;
      if (step_i && head_i.vld) begin
        issue_instr_o <= instr_d;
        trace_pc_o    <= trace_d;
      end
    end
  end

  assert_half_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (step_i && half_i && head_i.vld) |=> (issue_instr_o[INSTR_W-1:HALF_W] == '0));

  assert_idle_no_issue_R10: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> !issue_valid_o);

  assert_empty_no_issue_R7: assert property (@(posedge clk) disable iff (rst)
    !head_i.vld |=> !issue_valid_o);
endmodule

// File: rtl/dual_width_prefetch.sv
module dual_width_prefetch
  import pfq_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_i,
  input  logic            flush_i,
  input  logic [PC_W-1:0] flush_pc_i,
  input  logic            half_mode_i,
  output logic [PC_W-1:0] mem_addr_o,
  output logic            mem_half_o,
  input  logic [31:0]     mem_rdata_i,
  output logic            issue_valid_o,
  output logic [31:0]     issue_instr_o,
  output logic [PC_W-1:0] trace_pc_o,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc;
  slot_t           head;

  pfq_pc_reg #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_i),
    .flush_i    (flush_i),
    .flush_pc_i (flush_pc_i),
    .half_i     (half_mode_i),
    .pc_o       (pc)
  );

  pfq_slot_queue u_queue (
    .clk          (clk),
    .rst          (rst),
    .step_i       (step_i),
    .flush_i      (flush_i),
    .fetch_word_i (mem_rdata_i),
    .head_o       (head)
  );

  pfq_issue #(.PC_W(PC_W)) u_issue (
    .clk           (clk),
    .rst           (rst),
    .step_i        (step_i),
    .half_i        (half_mode_i),
    .head_i        (head),
    .pc_i          (pc),
    .issue_valid_o (issue_valid_o),
    .issue_instr_o (issue_instr_o),
    .trace_pc_o    (trace_pc_o)
  );

  assign mem_addr_o = pc;
  assign mem_half_o = half_mode_i;
  assign pc_o       = pc;

  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (step_i && !flush_i) |=> (mem_addr_o != $past(mem_addr_o)));
endmodule

// File: tb/tb_dual_width_prefetch.sv
module tb_dual_width_prefetch;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic            step_i, flush_i, half_mode_i;
  logic [PC_W-1:0] flush_pc_i;
  logic [PC_W-1:0] mem_addr_o;
  logic            mem_half_o;
  logic [31:0]     mem_rdata_i;
  logic            issue_valid_o;
  logic [31:0]     issue_instr_o;
  logic [PC_W-1:0] trace_pc_o, pc_o;

  int n_checks = 0;
  int n_fails  = 0;

  logic            m_v0, m_v1;
  logic [31:0]     m_w0, m_w1;
  logic [PC_W-1:0] m_pc;

  always #10 clk = ~clk;

  function automatic logic [31:0] mem_f(input logic [PC_W-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [PC_W-1:0] trace_f(input logic [PC_W-1:0] pc, input logic half);
    logic [PC_W-1:0] lag;
    lag = half ? 4 : 8;
    return (pc < lag) ? '0 : pc - lag;
  endfunction

  assign mem_rdata_i = mem_f(mem_addr_o);

  dual_width_prefetch #(.PC_W(PC_W)) dut (
    .clk(clk), .rst(rst), .step_i(step_i), .flush_i(flush_i),
    .flush_pc_i(flush_pc_i), .half_mode_i(half_mode_i),
    .mem_addr_o(mem_addr_o), .mem_half_o(mem_half_o), .mem_rdata_i(mem_rdata_i),
    .issue_valid_o(issue_valid_o), .issue_instr_o(issue_instr_o),
    .trace_pc_o(trace_pc_o), .pc_o(pc_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, compare at the next falling edge.
  task automatic cycle(input logic st, input logic fl, input logic [PC_W-1:0] tgt,
                       input logic md, input string tag);
    logic            e_iv;
    logic [31:0]     e_in;
    logic [PC_W-1:0] e_tr;
    step_i = st; flush_i = fl; flush_pc_i = tgt; half_mode_i = md;
    #1;
    check("R2 fetch address", 64'(mem_addr_o), 64'(m_pc));
    check("R2 fetch size",    64'(mem_half_o), 64'(md));
    e_iv = st && m_v0;
    e_in = md ? {16'h0, m_w0[15:0]} : m_w0;
    e_tr = trace_f(m_pc, md);
    if (st) begin
      if (fl) begin
        m_v0 = 1'b0; m_v1 = 1'b0; m_pc = tgt;
      end else begin
        m_v0 = m_v1; m_w0 = m_w1;
        m_v1 = 1'b1; m_w1 = mem_f(m_pc);
        m_pc = m_pc + (md ? 2 : 4);
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " issue valid (R3/R7/R10)"}, 64'(issue_valid_o), 64'(e_iv));
    if (e_iv) begin
      check({tag, md ? " R8 half instr" : " R3 word instr"}, 64'(issue_instr_o), 64'(e_in));
      check({tag, " R9 trace pc"}, 64'(trace_pc_o), 64'(e_tr));
    end
    check({tag, " R4/R5 pc"}, 64'(pc_o), 64'(m_pc));
  endtask

  initial begin
    #(200000 * 20);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; step_i = 0; flush_i = 0; flush_pc_i = '0; half_mode_i = 0;
    m_v0 = 0; m_v1 = 0; m_w0 = '0; m_w1 = '0; m_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset issue valid", 64'(issue_valid_o), 64'(0));
    check("R1 reset pc", 64'(pc_o), 64'(0));

    // R1: first issue on third step, trace saturates at 0 (8-8)
    cycle(1, 0, '0, 0, "R1 step1");
    cycle(1, 0, '0, 0, "R1 step2");
    cycle(1, 0, '0, 0, "R1 step3");
    // R10: idle cycles with noisy flush/mode have no effect
    cycle(0, 1, 32'h40, 1, "R10 idle");
    cycle(0, 0, '0, 1, "R10 idle");
    // R6: flush step still issues slot 0; R5 load target
    cycle(1, 1, 32'h100, 0, "R6 flush");
    cycle(1, 0, '0, 0, "R7 gap1");
    cycle(0, 0, '0, 0, "R7 idle");
    cycle(1, 0, '0, 0, "R7 gap2");
    cycle(1, 0, '0, 0, "R7 first");
    // R9: refill in 16-bit mode from 0, issue in 32-bit mode: 4-8 saturates
    cycle(1, 1, 32'h0, 1, "R9 flush");
    cycle(1, 0, '0, 1, "R9 fill1");
    cycle(1, 0, '0, 1, "R9 fill2");
    cycle(1, 0, '0, 0, "R9 saturate");
    // R8: 16-bit issue
    cycle(1, 1, 32'h200, 1, "R8 flush");
    for (int i = 0; i < 6; i++) cycle(1, 0, '0, 1, "R8 half");

    for (int i = 0; i < 4000; i++) begin
      logic st, fl, md;
      logic [PC_W-1:0] tgt;
      st  = ($urandom_range(0, 3) != 0);
      fl  = ($urandom_range(0, 9) == 0);
      md  = ($urandom_range(0, 7) == 0) ? ~half_mode_i : half_mode_i;
      tgt = ($urandom_range(0, 3) == 0) ? PC_W'($urandom_range(0, 7) * 2)
                                        : ($urandom() & ~32'h1);
      cycle(st, fl, tgt, md, "RND");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule